// File: doc/BRIEF.md
# Selectable-Index Register File

This block holds sixteen 32-bit general registers behind a single combined read/write port. The register number is not an input of its own. A four-way multiplexer takes it from the instruction word. The multiplexer can pick one of three four-bit instruction fields, or a fixed index that always points at the return-address register, number 15. That fixed input lets call and return sequences reach that register no matter how the instruction is encoded.

The read and the write use the same selected index. A write is taken on the rising clock edge while the write strobe is high. The selected entry is read combinationally. Entry 0 always reads as zero, and a write aimed at it changes nothing. The read value reaches the shared bus only while the drive enable is high. At all other times the output is forced to zero in place of a tri-state driver, and a bus-valid flag marks when the value is being driven.

Top module: `regsel_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register to zero, and it takes priority over a write in the same cycle. After reset every index reads zero.
- R2: With `wr_en` high at a rising edge, `wr_data` is stored in the selected register. Once the edge has passed, the register reads back the stored value with no further clock.
- R3: With `wr_en` low, a rising edge leaves every register unchanged, whatever `wr_data`, `instr` and `reg_sel` are.
- R4: Register 0 always reads zero, and a write to it through any select code is discarded.
- R5: Select code 2'b00 takes the register number from `instr[27:24]`.
- R6: Select code 2'b01 takes the register number from `instr[23:20]`.
- R7: Select code 2'b10 takes the register number from `instr[3:0]`.
- R8: Select code 2'b11 addresses register 15 for both reads and writes, whatever the value of `instr`.
- R9: While `drive_en` is low, `rd_data` is zero and `bus_valid` is low. While `drive_en` is high, `bus_valid` is high and `rd_data` carries the selected register.
- R10: A write changes only the register addressed by the select in effect. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset that clears all registers |
| instr | input | 32 | Instruction word that supplies the register-number fields |
| reg_sel | input | 2 | Chooses the register number: 00 = bits 27:24, 01 = bits 23:20, 10 = bits 3:0, 11 = register 15 |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Value to be written, taken from the bus |
| drive_en | input | 1 | Puts the read value on the bus |
| rd_data | output | 32 | Selected register value while driving, otherwise zero |
| bus_valid | output | 1 | High while `rd_data` is being driven |

## Verification
Every register is written with its own value. The writes rotate through the three field selects, so a wrong field position stores the value in the wrong entry. Every entry is then read back through each of the three fields. On each read, the two fields not in use and the rest of the word are filled with pseudo-random values, so a mux that reads the wrong field returns another entry's value. Select 11 is tried with random instruction words, and its result is compared with a read of index 15 through a field select. Further runs drive writes toward entry 0, cycles with the strobe low but data present, reads with the drive enable low, and a reset with the strobe held high. Each of these runs shows a separate fault: a writable zero entry, a spurious store, a leaking bus, or a reset that loses to the write.

// File: rtl/regsel_pkg.sv
package regsel_pkg;

   typedef enum logic [1:0] {
      SEL_FIELD_HI  = 2'b00,
      SEL_FIELD_MID = 2'b01,
      SEL_FIELD_LO  = 2'b10,
      SEL_LINK      = 2'b11
   } regsel_e;

endpackage

// File: rtl/regsel_addr_mux.sv
module regsel_addr_mux
   import regsel_pkg::*;
#(
   parameter int INSTR_W  = 32,
   parameter int ADDR_W   = 4,
   parameter int HI_LSB   = 24,
   parameter int MID_LSB  = 20,
   parameter int LO_LSB   = 0,
   parameter int LINK_IDX = 15
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [1:0]         sel,
   output logic [ADDR_W-1:0]  idx
);

   localparam logic [ADDR_W-1:0] LinkConst = ADDR_W'(LINK_IDX);

   logic [ADDR_W-1:0] field_hi;
   logic [ADDR_W-1:0] field_mid;
   logic [ADDR_W-1:0] field_lo;
   logic              unused_instr_bits;

   assign field_hi  = instr[HI_LSB  +: ADDR_W];
   assign field_mid = instr[MID_LSB +: ADDR_W];
   assign field_lo  = instr[LO_LSB  +: ADDR_W];
   assign unused_instr_bits = ^instr;

   always_comb begin
      case (regsel_e'(sel))
         SEL_FIELD_HI:  idx = field_hi;
         SEL_FIELD_MID: idx = field_mid;
         SEL_FIELD_LO:  idx = field_lo;
         default:       idx = LinkConst;
      endcase
   end

endmodule

// File: rtl/regsel_storage.sv
module regsel_storage #(
   parameter int DATA_W        = 32,
   parameter int NUM_REGS      = 16,
   parameter int ADDR_W        = 4,
   parameter bit HARDWIRE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_raw
);

   logic [NUM_REGS-1:0][DATA_W-1:0] bank;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
      if (g == 0 && HARDWIRE_ZERO) begin : g_tied
         assign bank[g] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         logic              hit;
         assign hit = wr_en && (idx == ADDR_W'(g));
         always_ff @(posedge clk) begin
            if (rst) begin
               q <= '0;
            end else if (hit) begin
               q <= wr_data;
            end
         end
         assign bank[g] = q;
      end
   end

   assign rd_raw = bank[idx];

endmodule

// File: rtl/regsel_bus_drive.sv
module regsel_bus_drive #(
   parameter int DATA_W = 32
) (
   input  logic              drive_en,
   input  logic [DATA_W-1:0] rd_raw,
   output logic [DATA_W-1:0] rd_data,
   output logic              bus_valid
);

   assign rd_data   = drive_en ? rd_raw : '0;
   assign bus_valid = drive_en;

endmodule

// File: rtl/regsel_regfile.sv
module regsel_regfile #(
   parameter int DATA_W        = 32,
   parameter int NUM_REGS      = 16,
   parameter int INSTR_W       = 32,
   parameter int HI_LSB        = 24,
   parameter int MID_LSB       = 20,
   parameter int LO_LSB        = 0,
   parameter int LINK_IDX      = 15,
   parameter bit HARDWIRE_ZERO = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr,
   input  logic [1:0]         reg_sel,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               drive_en,
   output logic [DATA_W-1:0]  rd_data,
   output logic               bus_valid
);

   localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   if (NUM_REGS < 2 || (1 << ADDR_W) != NUM_REGS) begin : g_bad_depth
      $error("regsel_regfile: NUM_REGS must be a power of two, at least 2");
   end
   if (HI_LSB + ADDR_W > INSTR_W || MID_LSB + ADDR_W > INSTR_W ||
       LO_LSB + ADDR_W > INSTR_W) begin : g_bad_field
      $error("regsel_regfile: a register field lies outside the instruction");
   end
   if (LINK_IDX < 0 || LINK_IDX >= NUM_REGS) begin : g_bad_link
      $error("regsel_regfile: LINK_IDX out of range");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("regsel_regfile: DATA_W must be positive");
   end

   logic [ADDR_W-1:0] sel_idx;
   logic [DATA_W-1:0] rd_raw;

   regsel_addr_mux #(
      .INSTR_W (INSTR_W),
      .ADDR_W  (ADDR_W),
      .HI_LSB  (HI_LSB),
      .MID_LSB (MID_LSB),
      .LO_LSB  (LO_LSB),
      .LINK_IDX(LINK_IDX)
   ) u_mux (
      .instr(instr),
      .sel  (reg_sel),
      .idx  (sel_idx)
   );

   regsel_storage #(
      .DATA_W       (DATA_W),
      .NUM_REGS     (NUM_REGS),
      .ADDR_W       (ADDR_W),
      .HARDWIRE_ZERO(HARDWIRE_ZERO)
   ) u_store (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .idx    (sel_idx),
      .wr_data(wr_data),
      .rd_raw (rd_raw)
   );

   regsel_bus_drive #(
      .DATA_W(DATA_W)
   ) u_drive (
      .drive_en (drive_en),
      .rd_raw   (rd_raw),
      .rd_data  (rd_data),
      .bus_valid(bus_valid)
   );

endmodule

// File: rtl/regsel_regfile_chk.sv
module regsel_regfile_chk #(
   parameter int DATA_W        = 32,
   parameter int INSTR_W       = 32,
   parameter int HI_LSB        = 24,
   parameter int MID_LSB       = 20,
   parameter int LO_LSB        = 0,
   parameter int LINK_IDX      = 15,
   parameter bit HARDWIRE_ZERO = 1'b1
) (
   input logic               clk,
   input logic               rst,
   input logic [INSTR_W-1:0] instr,
   input logic [1:0]         reg_sel,
   input logic               wr_en,
   input logic [DATA_W-1:0]  wr_data,
   input logic               drive_en,
   input logic [DATA_W-1:0]  rd_data,
   input logic               bus_valid
);

   logic [3:0] ptr;
   logic       primed;
   logic       unused_chk;

   assign unused_chk = ^instr;

   always_comb begin
      case (reg_sel)
         2'b00:   ptr = instr[HI_LSB  +: 4];
         2'b01:   ptr = instr[MID_LSB +: 4];
         2'b10:   ptr = instr[LO_LSB  +: 4];
         default: ptr = 4'(LINK_IDX);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) primed <= 1'b0;
      else     primed <= 1'b1;
   end

   // R9: quiet bus while not driving
   a_r9_quiet_bus: assert property (@(posedge clk) disable iff (rst)
      !drive_en |-> (rd_data == '0 && !bus_valid));

   // R9: valid flag follows the drive enable
   a_r9_valid_flag: assert property (@(posedge clk) disable iff (rst)
      drive_en |-> bus_valid);

   // R1: the first cycle after reset reads zero
   a_r1_cleared: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && drive_en) |-> rd_data == '0);

   // R2: value written on the previous edge reads back at the same index
   a_r2_readback: assert property (@(posedge clk) disable iff (rst)
      (primed && $past(wr_en) && drive_en && $past(ptr) == ptr &&
       (ptr != 4'd0 || !HARDWIRE_ZERO)) |-> rd_data == $past(wr_data));

   // R3: no strobe, same selection, then the read value does not move
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      (primed && !$past(wr_en) && $past(drive_en) && drive_en &&
       $stable(instr) && $stable(reg_sel)) |-> $stable(rd_data));

   // R8: write and read through the fixed link select meet in one register
   a_r8_link: assert property (@(posedge clk) disable iff (rst)
      (primed && $past(wr_en) && $past(reg_sel) == 2'b11 &&
       reg_sel == 2'b11 && drive_en) |-> rd_data == $past(wr_data));

   if (HARDWIRE_ZERO) begin : g_zero_chk
      // R4: index zero never reads a value
      a_r4_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
         (drive_en && ptr == 4'd0) |-> rd_data == '0);
   end

endmodule

bind regsel_regfile regsel_regfile_chk #(
   .DATA_W       (DATA_W),
   .INSTR_W      (INSTR_W),
   .HI_LSB       (HI_LSB),
   .MID_LSB      (MID_LSB),
   .LO_LSB       (LO_LSB),
   .LINK_IDX     (LINK_IDX),
   .HARDWIRE_ZERO(HARDWIRE_ZERO)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .instr    (instr),
   .reg_sel  (reg_sel),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .drive_en (drive_en),
   .rd_data  (rd_data),
   .bus_valid(bus_valid)
);

// File: tb/regsel_regfile_test.sv
module regsel_regfile_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic [1:0]  reg_sel = 2'b00;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        drive_en = 1'b0;
   logic [31:0] rd_data;
   logic        bus_valid;

   always #5 clk = ~clk;

   regsel_regfile uut (
      .clk      (clk),
      .rst      (rst),
      .instr    (instr),
      .reg_sel  (reg_sel),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .drive_en (drive_en),
      .rd_data  (rd_data),
      .bus_valid(bus_valid)
   );

   int          vectors = 0;
   int          misses  = 0;
   bit          done    = 1'b0;
   logic [31:0] model [16];
   logic [31:0] seed = 32'h1234_5678;

   function automatic logic [31:0] next_rand();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   // field positions: 00 -> [27:24], 01 -> [23:20], 10 -> [3:0], 11 -> none
   function automatic logic [31:0] place(logic [1:0] s, logic [3:0] idx, logic [31:0] junk);
      logic [31:0] w;
      w = junk;
      case (s)
         2'b00:   w[27:24] = idx;
         2'b01:   w[23:20] = idx;
         2'b10:   w[3:0]   = idx;
         default: w = junk;
      endcase
      return w;
   endfunction

   function automatic logic [3:0] target(logic [1:0] s, logic [3:0] idx);
      return (s == 2'b11) ? 4'd15 : idx;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
   endtask

   task automatic do_write(logic [1:0] s, logic [3:0] idx, logic [31:0] data);
      logic [3:0] t;
      @(negedge clk);
      reg_sel = s;
      instr   = place(s, idx, next_rand());
      wr_data = data;
      wr_en   = 1'b1;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      t = target(s, idx);
      if (t != 4'd0) model[t] = data;
   endtask

   task automatic do_read(string tag, logic [1:0] s, logic [3:0] idx);
      @(negedge clk);
      reg_sel  = s;
      instr    = place(s, idx, next_rand());
      drive_en = 1'b1;
      #1;
      check(tag, rd_data, model[target(s, idx)]);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst     = 1'b1;
      wr_en   = 1'b1;             // R1: reset must win over this write
      wr_data = 32'hDEAD_BEEF;
      reg_sel = 2'b11;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst   = 1'b0;
      wr_en = 1'b0;
      for (int i = 0; i < 16; i++) model[i] = '0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         misses++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = '0;
      apply_reset();

      // R1: everything reads zero after reset
      for (int i = 0; i < 16; i++) do_read("R1 reset value", 2'b00, 4'(i));
      check("R9 valid while driving", {31'b0, bus_valid}, 32'd1);

      // R10 / R5-R7: fill every entry, rotating the field select
      for (int i = 0; i < 16; i++)
         do_write(2'(i % 3), 4'(i), 32'h9E37_79B9 * (i + 1));
      for (int i = 0; i < 16; i++) begin
         do_read((i == 0) ? "R4 zero via hi" : "R5 hi field",  2'b00, 4'(i));
         do_read((i == 0) ? "R4 zero via mid" : "R6 mid field", 2'b01, 4'(i));
         do_read((i == 0) ? "R4 zero via lo" : "R7 lo field",  2'b10, 4'(i));
      end

      // R2: immediate readback after a single write, others untouched (R10)
      do_write(2'b01, 4'd7, 32'h0BAD_F00D);
      do_read("R2 readback", 2'b01, 4'd7);
      for (int i = 0; i < 16; i++) do_read("R10 neighbours", 2'b10, 4'(i));

      // R8: link select ignores the instruction word
      do_write(2'b11, 4'd3, 32'hCAFE_0015);
      for (int k = 0; k < 8; k++) do_read("R8 link read", 2'b11, 4'(k));
      do_read("R8 link via field", 2'b00, 4'd15);
      do_read("R8 reg3 untouched", 2'b00, 4'd3);

      // R3: strobe low leaves everything unchanged
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         reg_sel = 2'(k);
         instr   = place(2'(k), 4'(k + 4), next_rand());
         wr_data = next_rand();
         wr_en   = 1'b0;
         @(posedge clk);
      end
      for (int i = 0; i < 16; i++) do_read("R3 no strobe", 2'b00, 4'(i));

      // R4: writes to index zero are discarded on every field
      for (int s = 0; s < 3; s++) begin
         do_write(2'(s), 4'd0, 32'hFFFF_FFFF);
         do_read("R4 zero after write", 2'(s), 4'd0);
      end

      // R9: drive enable low forces a quiet bus
      for (int i = 1; i < 16; i += 4) begin
         @(negedge clk);
         drive_en = 1'b0;
         reg_sel  = 2'b00;
         instr    = place(2'b00, 4'(i), next_rand());
         #1;
         check("R9 quiet data", rd_data, 32'h0);
         check("R9 quiet valid", {31'b0, bus_valid}, 32'd0);
      end
      do_read("R9 driven again", 2'b00, 4'd13);
      check("R9 valid flag", {31'b0, bus_valid}, 32'd1);

      // R1: second reset with a competing write, then all zero
      apply_reset();
      for (int i = 0; i < 16; i++) do_read("R1 reset after data", 2'b01, 4'(i));
      do_read("R1 link after reset", 2'b11, 4'd0);

      done = 1'b1;
      report();
      $finish;
   end

endmodule